// File: doc/BRIEF.md
# UART Character Buffers with Receive and Transmit Trigger Levels

This block holds the character queues of one serial channel. The host loads outgoing characters into a transmit queue, and the serializer drains that queue one character per strobe. The deserializer loads incoming characters into a receive queue, and the host drains that queue. Each receive entry carries the 8-bit character together with three status bits that describe how that character arrived.

Each direction has its own trigger threshold. Software chooses the threshold from a fixed four-entry table, or from a 4-bit programmable value that is scaled by four. The threshold drives a level-sensitive interrupt request. It also drives a DMA request line, which is a two-state machine with hysteresis per direction.

A buffer-enable input switches between queued mode and single-character mode. In queued mode the queues hold 64 entries. In single-character mode each queue holds one entry and the threshold is one character. Separate flush strobes empty each queue on its own. A character that arrives at a full queue is dropped and sets a sticky overrun flag.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset both counts are 0, both overrun flags are 0, both DMA lines are 0, `rx_irq` is 0 and `tx_irq` is 1. Buffering is off after reset, so the capacity and the threshold are both 1.
- R2: Both queues return entries in arrival order. The receive head shows the data byte on `rx_rdata` and its status bits on `rx_rerr`. Bit 0 is parity, bit 1 is framing and bit 2 is break, and the bits are stored unchanged with their byte. The transmit head shows on `tx_data`.
- R3: The capacity is 64 when `fifo_en`=1 and 1 when `fifo_en`=0. A push that finds count = capacity is discarded and sets that direction's sticky overrun flag. The count never exceeds 64.
- R4: Push acceptance is judged on the count before the clock edge. A push and a pop in the same cycle on a full queue give one pop, and the push overruns. On an empty queue they give one push, and the pop is ignored.
- R5: With `fifo_en`=1 and a nonzero program field, the threshold is 4 × the field. With `fifo_en`=1 and a zero field, the select field picks the threshold. For receive, select 0, 1, 2 and 3 give 8, 16, 56 and 60. For transmit, they give 8, 16, 32 and 56. With `fifo_en`=0 the threshold is 1.
- R6: `rx_irq` is high exactly while rx_count ≥ rx threshold. `tx_irq` is high exactly while the transmit free space (capacity − count, floored at 0) ≥ tx threshold. Both follow the current count and settings with no delay.
- R7: The receive DMA machine has the states WAIT_FILL (`rx_dma_rdy`=0) and SERVICE (`rx_dma_rdy`=1). It moves WAIT_FILL→SERVICE on the edge where rx_count ≥ threshold. It moves SERVICE→WAIT_FILL on the edge where rx_count = 0.
- R8: The transmit DMA machine has the same two states. It moves WAIT_FILL→SERVICE on the edge where free space ≥ threshold. It moves SERVICE→WAIT_FILL on the edge where free space = 0.
- R9: A flush strobe empties only its own queue and clears only its own overrun flag. It takes priority over any push or pop on that queue in the same cycle.
- R10: Any change of `fifo_en` empties both queues and clears both overrun flags on that edge.
- R11: A pop strobe on an empty queue has no effect: the count stays 0 and the overrun flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 64-entry queued mode, 0 = single-character mode |
| rx_sel | input | 2 | Receive threshold table select |
| tx_sel | input | 2 | Transmit threshold table select |
| rx_prog | input | 4 | Receive programmable threshold / 4 (0 = use table) |
| tx_prog | input | 4 | Transmit programmable threshold / 4 (0 = use table) |
| rx_flush | input | 1 | Empty receive queue (one-cycle strobe) |
| tx_flush | input | 1 | Empty transmit queue (one-cycle strobe) |
| host_wr | input | 1 | Host pushes a transmit character |
| host_wdata | input | 8 | Transmit character |
| host_rd | input | 1 | Host pops the receive head |
| rx_rdata | output | 8 | Receive head data byte |
| rx_rerr | output | 3 | Receive head status {break, framing, parity} |
| ser_pop | input | 1 | Serializer takes the transmit head |
| tx_data | output | 8 | Transmit head character |
| des_push | input | 1 | Deserializer delivers a character |
| des_data | input | 8 | Received character |
| des_err | input | 3 | Received status {break, framing, parity} |
| rx_count | output | 7 | Receive queue occupancy |
| tx_count | output | 7 | Transmit queue occupancy |
| rx_irq | output | 1 | Receive threshold interrupt request |
| tx_irq | output | 1 | Transmit threshold interrupt request |
| rx_dma_rdy | output | 1 | Receive DMA request |
| tx_dma_rdy | output | 1 | Transmit DMA request |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_ovr | output | 1 | Sticky transmit overrun |

## Verification
Single-character mode is exercised with back-to-back arrivals. This shows whether capacity and threshold really drop to one. A receive fill to exactly 58 entries, held while every select value and two program values are swept, separates each table entry and the program-over-table priority on `rx_irq`. Filling both queues to 64 and then issuing push and pop together separates pop-before-push ordering from a design that accepts the push. A random phase mixes all strobes with rare flushes and mode changes. That phase catches DMA hysteresis edges, and also cross-talk between the two flushes, that the directed steps miss.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic {
        WAIT_FILL = 1'b0,
        SERVICE   = 1'b1
    } dma_state_t;

    localparam int ERR_W  = 3;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic [CW-1:0] free,
    output logic          ovr
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop, push_lost;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push   = push && (count < cap);
        push_lost = push && !(count < cap);
        do_pop    = pop && (count != '0);
        free      = (count >= cap) ? '0 : cap - count;
        dout      = mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push_lost) ovr <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/trig_level.sv
module trig_level #(
    parameter bit IS_RX = 1'b1,
    parameter int LW    = 7
) (
    input  logic          en,
    input  logic [1:0]    sel,
    input  logic [3:0]    prog,
    output logic [LW-1:0] level
);

    logic [LW-1:0] table_lvl;

    generate
        if (IS_RX) begin : g_rx_table
            always_comb begin
                unique case (sel)
                    2'd0: table_lvl = LW'(8);
                    2'd1: table_lvl = LW'(16);
                    2'd2: table_lvl = LW'(56);
                    default: table_lvl = LW'(60);
                endcase
            end
        end else begin : g_tx_table
            always_comb begin
                unique case (sel)
                    2'd0: table_lvl = LW'(8);
                    2'd1: table_lvl = LW'(16);
                    2'd2: table_lvl = LW'(32);
                    default: table_lvl = LW'(56);
                endcase
            end
        end
    endgenerate

    always_comb begin
        if (!en)               level = LW'(1);
        else if (prog != 4'd0) level = LW'({prog, 2'b00});
        else                   level = table_lvl;
    end

endmodule

// File: rtl/ready_fsm.sv
module ready_fsm
    import uart_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic drop,
    output logic rdy
);

    dma_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            WAIT_FILL: if (arm)  state_nxt = SERVICE;
            SERVICE:   if (drop) state_nxt = WAIT_FILL;
            default:   state_nxt = WAIT_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WAIT_FILL;
        else        state <= state_nxt;
    end

    always_comb begin
        rdy = (state == SERVICE);
    end

endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    rx_sel,
    input  logic [1:0]    tx_sel,
    input  logic [3:0]    rx_prog,
    input  logic [3:0]    tx_prog,
    input  logic          rx_flush,
    input  logic          tx_flush,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    rx_rdata,
    output logic [2:0]    rx_rerr,
    input  logic          ser_pop,
    output logic [7:0]    tx_data,
    input  logic          des_push,
    input  logic [7:0]    des_data,
    input  logic [2:0]    des_err,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_count,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          rx_dma_rdy,
    output logic          tx_dma_rdy,
    output logic          rx_ovr,
    output logic          tx_ovr
);

    localparam int RXW = $bits(rx_entry_t);

    logic          en_q, flush_all;
    logic [CW-1:0] cap, rx_lvl, tx_lvl, rx_free, tx_free;
    rx_entry_t     rx_in, rx_head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    always_comb begin
        flush_all = (en_q != fifo_en);
        cap       = fifo_en ? CW'(DEPTH) : CW'(1);
        rx_in     = '{err: des_err, data: des_data};
        rx_rdata  = rx_head.data;
        rx_rerr   = rx_head.err;
    end

    fifo_store #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush || flush_all), .cap(cap),
        .push(des_push), .din(rx_in), .pop(host_rd), .dout(rx_head),
        .count(rx_count), .free(rx_free), .ovr(rx_ovr)
    );

    fifo_store #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush || flush_all), .cap(cap),
        .push(host_wr), .din(host_wdata), .pop(ser_pop), .dout(tx_data),
        .count(tx_count), .free(tx_free), .ovr(tx_ovr)
    );

    trig_level #(.IS_RX(1'b1), .LW(CW)) u_rx_lvl (
        .en(fifo_en), .sel(rx_sel), .prog(rx_prog), .level(rx_lvl)
    );

    trig_level #(.IS_RX(1'b0), .LW(CW)) u_tx_lvl (
        .en(fifo_en), .sel(tx_sel), .prog(tx_prog), .level(tx_lvl)
    );

    always_comb begin
        rx_irq = (rx_count >= rx_lvl);
        tx_irq = (tx_free >= tx_lvl);
    end

    ready_fsm u_rx_dma (
        .clk(clk), .rst_n(rst_n),
        .arm(rx_count >= rx_lvl), .drop(rx_count == '0), .rdy(rx_dma_rdy)
    );

    ready_fsm u_tx_dma (
        .clk(clk), .rst_n(rst_n),
        .arm(tx_free >= tx_lvl), .drop(tx_free == '0), .rdy(tx_dma_rdy)
    );

endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_flush,
    input logic          tx_flush,
    input logic          flush_all,
    input logic          host_rd,
    input logic          des_push,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] tx_free,
    input logic          rx_ovr,
    input logic          rx_dma_rdy,
    input logic          tx_dma_rdy
);

    AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH)); // R3

    AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr && !rx_flush && !flush_all |=> rx_ovr); // R3

    AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_flush && !flush_all |=> (int'(rx_count) <= int'($past(rx_count)) + 1)); // R4

    AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> rx_count == '0); // R9

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (rx_count == '0) && (tx_count == '0)); // R10

    AST_RX_DMA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_rdy && rx_count == '0 |=> !rx_dma_rdy); // R7

    AST_TX_DMA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_rdy && tx_free == '0 |=> !tx_dma_rdy); // R8

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && rx_count == '0 && !des_push |=> rx_count == '0); // R11

endmodule

bind uart_fifo_trig uart_fifo_trig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .flush_all(flush_all), .host_rd(host_rd), .des_push(des_push),
    .rx_count(rx_count), .tx_count(tx_count), .tx_free(tx_free),
    .rx_ovr(rx_ovr), .rx_dma_rdy(rx_dma_rdy), .tx_dma_rdy(tx_dma_rdy)
);

// File: tb/uart_fifo_trig_bench.sv
`timescale 1ns/1ps
module uart_fifo_trig_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] rx_sel = '0, tx_sel = '0;
    logic [3:0] rx_prog = '0, tx_prog = '0;
    logic       rx_flush = 1'b0, tx_flush = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, ser_pop = 1'b0, des_push = 1'b0;
    logic [7:0] host_wdata = '0, des_data = '0;
    logic [2:0] des_err = '0;
    logic [7:0] rx_rdata, tx_data;
    logic [2:0] rx_rerr;
    logic [6:0] rx_count, tx_count;
    logic       rx_irq, tx_irq, rx_dma_rdy, tx_dma_rdy, rx_ovr, tx_ovr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_fifo_trig u_uart_fifo_trig (.*);

    // reference model state
    logic [10:0] m_rxq[$];
    logic [7:0]  m_txq[$];
    bit m_rx_ovr, m_tx_ovr, m_rx_svc, m_tx_svc, m_prev_en;

    function automatic int lvl(bit is_rx, bit en, int sel, int prog);
        if (!en) return 1;
        if (prog != 0) return prog * 4;
        if (is_rx) begin
            case (sel) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
        end
        case (sel) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
    endfunction

    function automatic int capv(); return fifo_en ? 64 : 1; endfunction
    function automatic int m_txfree();
        return (m_txq.size() >= capv()) ? 0 : capv() - m_txq.size();
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rxq.delete(); m_txq.delete();
            m_rx_ovr = 0; m_tx_ovr = 0; m_rx_svc = 0; m_tx_svc = 0; m_prev_en = 0;
        end else begin
            int rl, tl, rs, ts;
            bit fa;
            rl = lvl(1, fifo_en, rx_sel, rx_prog);
            tl = lvl(0, fifo_en, tx_sel, tx_prog);
            rs = m_rxq.size();
            ts = m_txq.size();
            if (!m_rx_svc) m_rx_svc = (rs >= rl); else if (rs == 0) m_rx_svc = 0;
            if (!m_tx_svc) m_tx_svc = (m_txfree() >= tl); else if (m_txfree() == 0) m_tx_svc = 0;
            fa = (fifo_en != m_prev_en);
            m_prev_en = fifo_en;
            if (fa || rx_flush) begin
                m_rxq.delete(); m_rx_ovr = 0;
            end else begin
                if (host_rd && rs > 0) void'(m_rxq.pop_front());
                if (des_push) begin
                    if (rs < capv()) m_rxq.push_back({des_err, des_data});
                    else m_rx_ovr = 1;
                end
            end
            if (fa || tx_flush) begin
                m_txq.delete(); m_tx_ovr = 0;
            end else begin
                if (ser_pop && ts > 0) void'(m_txq.pop_front());
                if (host_wr) begin
                    if (ts < capv()) m_txq.push_back(host_wdata);
                    else m_tx_ovr = 1;
                end
            end
            #2;
            if (!done) begin
                chk(rx_count == m_rxq.size(), "R3 rx_count", rx_count, m_rxq.size());
                chk(tx_count == m_txq.size(), "R3 tx_count", tx_count, m_txq.size());
                chk(rx_ovr == m_rx_ovr, "R3 rx_ovr", rx_ovr, m_rx_ovr);
                chk(tx_ovr == m_tx_ovr, "R3 tx_ovr", tx_ovr, m_tx_ovr);
                chk(rx_irq == (m_rxq.size() >= lvl(1, fifo_en, rx_sel, rx_prog)), "R6 rx_irq",
                    rx_irq, m_rxq.size() >= lvl(1, fifo_en, rx_sel, rx_prog));
                chk(tx_irq == (m_txfree() >= lvl(0, fifo_en, tx_sel, tx_prog)), "R6 tx_irq",
                    tx_irq, m_txfree() >= lvl(0, fifo_en, tx_sel, tx_prog));
                chk(rx_dma_rdy == m_rx_svc, "R7 rx_dma_rdy", rx_dma_rdy, m_rx_svc);
                chk(tx_dma_rdy == m_tx_svc, "R8 tx_dma_rdy", tx_dma_rdy, m_tx_svc);
                if (m_rxq.size() > 0)
                    chk({rx_rerr, rx_rdata} == m_rxq[0], "R2 rx head", {rx_rerr, rx_rdata}, m_rxq[0]);
                if (m_txq.size() > 0)
                    chk(tx_data == m_txq[0], "R2 tx head", tx_data, m_txq[0]);
            end
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            des_push = 0; host_rd = 0; host_wr = 0; ser_pop = 0; rx_flush = 0; tx_flush = 0;
        end
    endtask

    task automatic rx_put(int k);
        for (int i = 0; i < k; i++) begin
            des_push = 1; des_data = 8'(i * 7 + 3); des_err = 3'(i); cyc();
        end
    endtask

    task automatic tx_put(int k);
        for (int i = 0; i < k; i++) begin
            host_wr = 1; host_wdata = 8'(i * 5 + 1); cyc();
        end
    endtask

    // sample after the edge that follows the last input change
    task automatic settle();
        @(posedge clk); #3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(rx_count == 0 && tx_count == 0, "R1 counts", rx_count + tx_count, 0);
        chk(!rx_ovr && !tx_ovr && !rx_dma_rdy && !tx_dma_rdy, "R1 flags/dma",
            {rx_ovr, tx_ovr, rx_dma_rdy, tx_dma_rdy}, 0);
        chk(!rx_irq && tx_irq, "R1 irqs", {rx_irq, tx_irq}, 1);
        cyc();

        // single-character mode
        rx_put(2);
        #1 chk(rx_count == 1 && rx_ovr, "R3 disabled capacity 1", rx_count, 1);
        host_rd = 1; cyc();
        host_rd = 1; cyc();
        #1 chk(rx_count == 0 && rx_ovr, "R11 read on empty", rx_count, 0);
        tx_put(2);
        #1 chk(tx_count == 1 && tx_ovr, "R3 tx disabled overrun", tx_count, 1);

        // mode change flushes
        fifo_en = 1; cyc();
        #1 chk(rx_count == 0 && tx_count == 0 && !rx_ovr && !tx_ovr, "R10 enable flush",
               rx_count + tx_count, 0);

        // receive fill and drain with table 0
        rx_put(20);
        for (int i = 0; i < 20; i++) begin host_rd = 1; cyc(); end
        cyc(2);

        // threshold sweep at count 58
        rx_put(58);
        for (int s = 0; s < 4; s++) begin
            rx_sel = 2'(s); settle();
            chk(rx_irq == (s != 3), "R5 rx table", rx_irq, s != 3);
            @(negedge clk);
        end
        rx_prog = 15; settle(); chk(!rx_irq, "R5 prog 60", rx_irq, 0); @(negedge clk);
        rx_prog = 14; settle(); chk(rx_irq, "R5 prog 56", rx_irq, 1); @(negedge clk);
        rx_prog = 0; rx_sel = 0;

        // full queue, overrun, simultaneous push/pop
        rx_put(7);
        #1 chk(rx_count == 64 && rx_ovr, "R3 full overrun", rx_count, 64);
        des_push = 1; host_rd = 1; cyc();
        #1 chk(rx_count == 63, "R4 push+pop on full", rx_count, 63);
        tx_put(64);
        rx_flush = 1; des_push = 1; cyc();
        #1 chk(rx_count == 0 && !rx_ovr && tx_count == 64, "R9 rx flush only",
               rx_count, 0);
        host_rd = 1; des_push = 1; cyc();
        #1 chk(rx_count == 1, "R4 push+pop on empty", rx_count, 1);

        // transmit drain, table and program thresholds
        for (int s = 0; s < 4; s++) begin
            tx_sel = 2'(s);
            for (int i = 0; i < 20; i++) begin ser_pop = 1; cyc(); end
            tx_put(20);
        end
        tx_prog = 5; cyc(3);
        for (int i = 0; i < 30; i++) begin ser_pop = 1; cyc(); end
        tx_flush = 1; cyc();
        #1 chk(tx_count == 0 && rx_count == 1, "R9 tx flush only", tx_count, 0);
        tx_prog = 0;

        // random mix
        for (int i = 0; i < 6000; i++) begin
            des_push = ($urandom_range(0, 3) != 0);
            des_data = 8'($urandom); des_err = 3'($urandom);
            host_rd = ($urandom_range(0, 2) == 0);
            host_wr = ($urandom_range(0, 2) != 0);
            host_wdata = 8'($urandom);
            ser_pop = ($urandom_range(0, 3) == 0);
            rx_flush = ($urandom_range(0, 499) == 0);
            tx_flush = ($urandom_range(0, 499) == 0);
            if ($urandom_range(0, 199) == 0) rx_sel = 2'($urandom);
            if ($urandom_range(0, 199) == 0) tx_sel = 2'($urandom);
            if ($urandom_range(0, 299) == 0) rx_prog = 4'($urandom);
            if ($urandom_range(0, 299) == 0) tx_prog = 4'($urandom);
            if ($urandom_range(0, 999) == 0) fifo_en = ~fifo_en;
            @(negedge clk);
            if (i % 1000 == 999) begin
                des_push = 0; host_wr = 0;
                repeat (70) begin host_rd = 1; ser_pop = 1; @(negedge clk); end
            end
        end
        cyc(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule